// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Key Service

The block is a watchdog timer that runs on the oscillator clock and asks for a system reset when software stops servicing it in time. A control register selects one of seven power-of-two timeout periods (or switches the timer off), turns window mode on or off, and decides whether the count freezes while a debugger holds the processor halted. Software services the timer by writing an arming key and then a firing key to a separate service register. Any wrong write raises a reset request.

In window mode the timer also punishes service that comes too early. A service-register write during the first three quarters of the running period is treated as a fault. Only writes in the last quarter are accepted. Once the firing key restarts the period, the window closes again until the count has gone three quarters of the way through.

In user mode the timer settings can be written once after reset. A special-mode input lifts that lock for the period and window bits. The freeze bit can be written only once, whatever the mode. The reset request is a one-cycle pulse. The surrounding reset generator turns it into a system reset, and the block's own reset input clears every field and re-arms the locks.

Top module: `wdog_window`

## Requirements
- R1: After reset the control register reads 0x00, `rst_req` is low, and the timer stays disabled, so no reset request ever appears while the control register is not written.
- R2: The rate field (control bits 2:0) selects the timeout period in oscillator cycles, where `T` is the parameter `EXP_TRIM`. Code 000 turns the timer off. Codes 001 to 111 select 2^(14-T), 2^(16-T), 2^(18-T), 2^(20-T), 2^(22-T), 2^(23-T) and 2^(24-T) cycles. With no service, `rst_req` rises exactly one period after the write that set the rate.
- R3: The control register (address `CTRL_ADDR`) reads back as follows: window enable at bit 7, freeze-in-debug at bit 6, rate at bits 2:0. Bits 5:3 read as zero, and the service register (address `SVC_ADDR`) reads as zero.
- R4: While `special_mode` is low, only the first control write after reset changes the window and rate fields. The freeze bit takes only the first control write after reset, whatever the mode.
- R5: While `special_mode` is high, the window and rate fields can be rewritten any number of times, and such writes do not use up the single user-mode write.
- R6: Writing 0x55 and then 0xAA to the service register restarts the period. The 0x55 may be repeated any number of times before the 0xAA.
- R7: When the timer is enabled, a service write of any value other than 0x55 or 0xAA raises a reset request. So does a 0xAA with no 0x55 before it. A faulty write also clears the armed state.
- R8: In window mode, a service write made while the count is below three quarters of the period raises a reset request. This includes any write right after a successful restart.
- R9: While the freeze bit is 1 and `dbg_active` is high, the count holds. While the freeze bit is 0, the count runs through debug.
- R10: While the rate field is 000, service writes are ignored: they raise no request and do not arm the firing key.
- R11: A valid 0xAA in the last cycle of a period restarts the period, and no timeout occurs. A timeout and a faulty write in the same cycle give one request pulse.
- R12: `rst_req` rises on the clock edge after the cause and stays high for exactly one cycle. After a timeout the count starts a new period.
- R13: An accepted control write with a nonzero rate starts a new period from zero. A special-mode write of rate 000 stops the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| dbg_active | input | 1 | Debugger has the processor halted |
| special_mode | input | 1 | Lifts the write-once lock on the window and rate fields |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The timeout of a period and a service write can fall on the same clock edge. The bench provokes this by counting cycles from a control write to the last cycle of a short period, then issuing the write on exactly that edge. A correct 0xAA there must win: no pulse appears, and a full new period follows. A faulty value there meets the timeout in the same cycle and must yield exactly one pulse, which the bench judges by sampling `rst_req` on that cycle and the next, and by counting pulses.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  // Exponent of the timeout period for a rate code; 0 means disabled.
  function automatic int unsigned rate_exp(input logic [2:0] code, input int unsigned trim);
    int unsigned e;
    case (code)
      3'd1:    e = 14;
      3'd2:    e = 16;
      3'd3:    e = 18;
      3'd4:    e = 20;
      3'd5:    e = 22;
      3'd6:    e = 23;
      3'd7:    e = 24;
      default: e = 0;
    endcase
    return (e == 0) ? 0 : e - trim;
  endfunction

endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       special,
  input  logic       wr_win,
  input  logic       wr_dstop,
  input  logic [2:0] wr_rate,
  output logic       win_q,
  output logic       dstop_q,
  output logic [2:0] rate_q,
  output logic       restart
);

  logic       lock_main_q, lock_dstop_q;
  logic       lock_main_d, lock_dstop_d;
  logic       win_d, dstop_d;
  logic [2:0] rate_d;
  logic       main_ok, dstop_ok;

  always_comb begin
    main_ok      = we && (special || !lock_main_q);
    dstop_ok     = we && !lock_dstop_q;
    lock_main_d  = lock_main_q | (we & ~special);
    lock_dstop_d = lock_dstop_q | we;
    win_d        = main_ok  ? wr_win   : win_q;
    rate_d       = main_ok  ? wr_rate  : rate_q;
    dstop_d      = dstop_ok ? wr_dstop : dstop_q;
    restart      = main_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_main_q  <= 1'b0;
      lock_dstop_q <= 1'b0;
      win_q        <= 1'b0;
      dstop_q      <= 1'b0;
      rate_q       <= 3'd0;
    end else begin
      lock_main_q  <= lock_main_d;
      lock_dstop_q <= lock_dstop_d;
      win_q        <= win_d;
      dstop_q      <= dstop_d;
      rate_q       <= rate_d;
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock_main_q && !special) |=> ($stable(rate_q) && $stable(win_q))); // R4

  AST_DSTOP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock_dstop_q) |=> $stable(dstop_q)); // R4

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned EXP_TRIM = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate,
  input  logic       freeze,
  input  logic       restart,
  output logic       timeout,
  output logic       win_open
);
  import wdg_pkg::*;

  localparam int unsigned CNT_W = 24 - EXP_TRIM;

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] mask;
  logic [4:0]       e;
  logic             en, at_end;

  always_comb begin
    e        = 5'(rate_exp(rate, EXP_TRIM));
    en       = (rate != 3'd0);
    period   = (CNT_W+1)'(1) << e;
    mask     = CNT_W'(period - 1'b1);
    at_end   = (count_q == mask);
    win_open = en && (count_q >= (mask - (mask >> 2)));
    timeout  = en && !restart && !freeze && at_end;
    if (!en || restart)  count_d = '0;
    else if (freeze)     count_d = count_q;
    else if (at_end)     count_d = '0;
    else                 count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (count_q <= mask)); // R2

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && freeze && !restart) |=> $stable(count_q)); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!timeout && !win_open)); // R10

endmodule

// File: rtl/wdg_service.sv
module wdg_service (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       en,
  input  logic       win,
  input  logic       win_open,
  output logic       restart,
  output logic       violation
);
  import wdg_pkg::*;

  logic armed_q, armed_d;

  always_comb begin
    armed_d   = armed_q;
    restart   = 1'b0;
    violation = 1'b0;
    if (!en) begin
      armed_d = 1'b0;
    end else if (we) begin
      if (win && !win_open) begin
        violation = 1'b1;
        armed_d   = 1'b0;
      end else if (wdata == KEY_ARM) begin
        armed_d = 1'b1;
      end else if (wdata == KEY_FIRE && armed_q) begin
        restart = 1'b1;
        armed_d = 1'b0;
      end else begin
        violation = 1'b1;
        armed_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> armed_q); // R6

endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned SVC_ADDR  = 1,
  parameter int unsigned EXP_TRIM  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dbg_active,
  input  logic              special_mode,
  output logic              rst_req
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(SVC_ADDR);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       ctrl_we, svc_we;
  logic       win_q, dstop_q;
  logic [2:0] rate_q;
  logic       ctrl_restart, svc_restart, violation;
  logic       timeout, win_open;
  logic       rst_req_q, rst_req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign ctrl_we = bus_we && (bus_addr == A_CTRL);
  assign svc_we  = bus_we && (bus_addr == A_SVC);

  wdg_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .we(ctrl_we), .special(special_mode),
    .wr_win(bus_wdata[7]), .wr_dstop(bus_wdata[6]), .wr_rate(bus_wdata[2:0]),
    .win_q(win_q), .dstop_q(dstop_q), .rate_q(rate_q), .restart(ctrl_restart)
  );

  wdg_counter #(.EXP_TRIM(EXP_TRIM)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .rate(rate_q),
    .freeze(dstop_q & dbg_active),
    .restart(ctrl_restart | svc_restart),
    .timeout(timeout), .win_open(win_open)
  );

  wdg_service u_svc (
    .clk(clk), .rst_n(rst_n_i), .we(svc_we), .wdata(bus_wdata),
    .en(rate_q != 3'd0), .win(win_q), .win_open(win_open),
    .restart(svc_restart), .violation(violation)
  );

  always_comb begin
    rst_req_d = (timeout | violation) & ~rst_req_q;
    if (bus_addr == A_CTRL) bus_rdata = {win_q, dstop_q, 3'b000, rate_q};
    else                    bus_rdata = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rst_req_q <= 1'b0;
    else          rst_req_q <= rst_req_d;
  end
  assign rst_req = rst_req_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    rst_req_q |=> !rst_req_q); // R12

  AST_EARLY_WRITE_TRIPS: assert property (@(posedge clk) disable iff (!rst_n_i)
    (svc_we && rate_q != 3'd0 && win_q && !win_open && !rst_req_q) |=> rst_req_q); // R8

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rate_q == 3'd0 && !rst_req_q) |=> !rst_req_q); // R10

endmodule

// File: tb/test_wdog_window.sv
`timescale 1ns/1ps
module test_wdog_window;

  localparam int unsigned TRIM = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       dbg_active, special_mode;
  logic       rst_req;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cycles = 0;

  // rate code (index+1) -> expected period with EXP_TRIM = 10
  localparam logic [6:0][15:0] PERIOD_TBL = {16'd16384, 16'd8192, 16'd4096,
                                              16'd1024, 16'd256, 16'd64, 16'd16};

  always #2.5 clk = ~clk;

  wdog_window #(.EXP_TRIM(TRIM)) i_wdog_window (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_active(dbg_active),
    .special_mode(special_mode), .rst_req(rst_req)
  );

  always @(negedge clk) begin
    cycles++;
    if (rst_req) pulses++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 4'd0; bus_wdata = 8'h00;
    dbg_active = 1'b0; special_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!rst_req && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    logic [7:0] r;
    int n, p0;

    // R1: reset state
    do_reset();
    rd(4'd0, r);
    check(r == 8'h00, "R1 ctrl after reset", r, 0);
    check(rst_req == 1'b0, "R1 rst_req after reset", rst_req, 0);
    p0 = pulses;
    repeat (200) @(negedge clk);
    check(pulses == p0, "R1 idle no request", pulses - p0, 0);

    // R2: table of rate codes and expected periods
    for (int i = 0; i < 7; i++) begin
      do_reset();
      wr(4'd0, 8'(i + 1));
      measure(n);
      check(n == int'(PERIOD_TBL[i]), $sformatf("R2 period code %0d", i + 1), n, int'(PERIOD_TBL[i]));
    end
    // R12: one-cycle pulse, then a fresh period
    @(negedge clk);
    check(rst_req == 1'b0, "R12 pulse width", rst_req, 0);
    measure(n);
    check(n == 16384 - 1, "R12 period after timeout", n, 16384 - 1);

    // R3, R4: layout and user-mode write-once
    do_reset();
    wr(4'd0, 8'hFF);
    rd(4'd0, r);
    check(r == 8'hC7, "R3 ctrl readback", r, 8'hC7);
    rd(4'd1, r);
    check(r == 8'h00, "R3 service reads zero", r, 0);
    @(negedge clk);
    wr(4'd0, 8'h01);
    rd(4'd0, r);
    check(r == 8'hC7, "R4 second user write ignored", r, 8'hC7);

    // R5: special-mode rewrite; freeze bit stays once-only
    do_reset();
    special_mode = 1'b1;
    wr(4'd0, 8'h45);
    rd(4'd0, r);
    check(r == 8'h45, "R5 first special write", r, 8'h45);
    @(negedge clk);
    wr(4'd0, 8'h83);
    rd(4'd0, r);
    check(r == 8'hC3, "R5 special rewrite, R4 freeze locked", r, 8'hC3);
    @(negedge clk);
    special_mode = 1'b0;
    wr(4'd0, 8'h05);
    rd(4'd0, r);
    check(r == 8'h45, "R5 user write still available", r, 8'h45);
    @(negedge clk);
    wr(4'd0, 8'h06);
    rd(4'd0, r);
    check(r == 8'h45, "R4 user lock after user write", r, 8'h45);

    // R6: repeated arming then firing keeps the timer quiet
    do_reset();
    wr(4'd0, 8'h01);
    p0 = pulses;
    for (int k = 0; k < 10; k++) begin
      wr(4'd1, 8'h55);
      wr(4'd1, 8'h55);
      wr(4'd1, 8'hAA);
      repeat (10) @(negedge clk);
    end
    check(pulses == p0, "R6 serviced no request", pulses - p0, 0);
    wr(4'd1, 8'h55);
    wr(4'd1, 8'hAA);
    measure(n);
    check(n == 16, "R6 restart from firing key", n, 16);

    // R7: faulty keys
    do_reset();
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h12);
    check(rst_req == 1'b1, "R7 bad value", rst_req, 1);
    @(negedge clk);
    wr(4'd1, 8'hAA);
    check(rst_req == 1'b1, "R7 fire without arm", rst_req, 1);
    @(negedge clk);
    wr(4'd1, 8'h55);
    wr(4'd1, 8'h56);
    @(negedge clk);
    wr(4'd1, 8'hAA);
    check(rst_req == 1'b1, "R7 fault clears arm", rst_req, 1);

    // R8: window mode, period 64, window opens at count 48
    do_reset();
    wr(4'd0, 8'h82);
    repeat (47) @(negedge clk);
    wr(4'd1, 8'h55);
    check(rst_req == 1'b1, "R8 write at count 47", rst_req, 1);
    wr(4'd1, 8'h55);
    check(rst_req == 1'b0, "R8 write at count 48 accepted", rst_req, 0);
    wr(4'd1, 8'h55);
    wr(4'd1, 8'hAA);
    check(rst_req == 1'b0, "R8 fire in window", rst_req, 0);
    wr(4'd1, 8'h55);
    check(rst_req == 1'b1, "R8 write right after restart", rst_req, 1);

    // R9: freeze in debug
    do_reset();
    dbg_active = 1'b1;
    wr(4'd0, 8'h41);
    p0 = pulses;
    repeat (100) @(negedge clk);
    check(pulses == p0, "R9 frozen no request", pulses - p0, 0);
    dbg_active = 1'b0;
    measure(n);
    check(n == 16, "R9 count held during freeze", n, 16);
    do_reset();
    dbg_active = 1'b1;
    wr(4'd0, 8'h01);
    measure(n);
    check(n == 16, "R9 runs in debug when bit clear", n, 16);
    dbg_active = 1'b0;

    // R10: disabled timer ignores service writes
    do_reset();
    wr(4'd1, 8'h12);
    check(rst_req == 1'b0, "R10 bad value ignored", rst_req, 0);
    wr(4'd1, 8'h55);
    wr(4'd0, 8'h01);
    wr(4'd1, 8'hAA);
    check(rst_req == 1'b1, "R10 arm ignored while disabled", rst_req, 1);

    // R11: service on the final cycle
    do_reset();
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h55);
    repeat (14) @(negedge clk);
    p0 = pulses;
    wr(4'd1, 8'hAA);
    check(pulses == p0 && rst_req == 1'b0, "R11 fire on last cycle", pulses - p0, 0);
    measure(n);
    check(n == 16, "R11 new period after last-cycle fire", n, 16);
    do_reset();
    wr(4'd0, 8'h01);
    repeat (15) @(negedge clk);
    p0 = pulses;
    wr(4'd1, 8'h12);
    check(rst_req == 1'b1, "R11 timeout with fault", rst_req, 1);
    @(negedge clk);
    check(pulses - p0 == 1, "R11 single pulse", pulses - p0, 1);

    // R13: nonzero rate write restarts, zero write stops
    do_reset();
    special_mode = 1'b1;
    wr(4'd0, 8'h02);
    repeat (40) @(negedge clk);
    wr(4'd0, 8'h01);
    measure(n);
    check(n == 16, "R13 restart on rate write", n, 16);
    @(negedge clk);
    wr(4'd0, 8'h00);
    p0 = pulses;
    repeat (100) @(negedge clk);
    check(pulses == p0, "R13 zero rate stops", pulses - p0, 0);
    special_mode = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule